// File: doc/BRIEF.md
# Nibble-Direction Parallel I/O Port

This block drives sixteen bidirectional pad lines grouped as four 4-bit nibbles. A small byte-wide register file sets the direction of each nibble and holds the output values. The pads are handled through separate output, output-enable and input signals, which connect to tri-state buffers outside the block. Reading a data byte returns the synchronized levels on the pads, whatever the direction of each line. Software can therefore read back what it drives, or use a line in both directions with care.

A static strap input, one bit per nibble, selects the level each nibble drives while reset is held. A nibble that will be used as an input should be strapped high, so that it does not pull external signals low before software turns it around. Output latches keep accepting writes while their nibble is an input. When the nibble is switched to output, it drives the last value written.

Top module: `nibble_gpio_port`

## Requirements
- R1: While reset is asserted, and after it is released with no write, every pad enable is 1 (all nibbles are outputs), and the direction register (address 0) reads 00h.
- R2: Under reset, each line of nibble n (lines 4n..4n+3) drives the value of strap bit n.
- R3: A write to address 0 stores bits 3:0 as the nibble directions. Bit n = 1 makes nibble n an input (its four enables go to 0). Bit n = 0 makes it an output. The new enables appear after the write's clock edge.
- R4: A write to address 1 loads the output latches of lines 7:0 (data bit i goes to line i). A write to address 2 loads lines 15:8 (data bit i goes to line 8+i). Each takes effect after the write's clock edge.
- R5: A read of address 1 returns pad input levels 7:0, and a read of address 2 returns levels 15:8, whatever the directions. Each level passes through two register stages, so a pad change is visible two clock edges later.
- R6: Writes to a data address update the latches of input nibbles too. Switching such a nibble to output then drives the value last written.
- R7: Bits 7:4 of the direction register read as 0. Address 3 reads 00h, and a write to it changes no output.
- R8: With write enable low, no latch or direction bit changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 4 | Reset drive level per nibble |
| reg_addr_i | input | 2 | Register address: 0 direction, 1 low data, 2 high data, 3 unused |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for reg_addr_i (combinational) |
| pad_in_i | input | 16 | Pad input levels |
| pad_out_o | output | 16 | Pad output values |
| pad_oe_o | output | 16 | Pad output enables, 1 = drive |

## Verification
A wrong direction bit shows on pad_oe_o one cycle after the write that caused it, because the enables leave the register with no further logic. A corrupted output latch shows on pad_out_o just as soon, and through the data readback two edges later when its nibble drives. A fault in the synchronizer or the read multiplexer hides until the affected byte is read. For that reason the pad levels are re-read after every random step, with external values that differ from the latched ones.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned NUM_NIB  = 4;
  localparam int unsigned LINES    = NIB_W * NUM_NIB;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NIB_PER_BYTE = BYTE_W / NIB_W;
  localparam int unsigned NUM_BYTES    = LINES / BYTE_W;
  localparam int unsigned SYNC_STAGES  = 2;

  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_LO   = 2'd1,
    ADDR_HI   = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_NIB-1:0] d_i,
  output logic [NUM_NIB-1:0] dir_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dir_o <= '0;
    else if (we_i) dir_o <= d_i;
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_NIB-1:0]   strap_i,
  input  logic [NUM_BYTES-1:0] byte_we_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  output logic [LINES-1:0]     q_o
);
  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    localparam int unsigned BYTE_IX = n / NIB_PER_BYTE;
    localparam int unsigned SLOT    = n % NIB_PER_BYTE;
    // strap is static; reset loads its level
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q_o[n*NIB_W +: NIB_W] <= {NIB_W{strap_i[n]}};
      else if (byte_we_i[BYTE_IX])
        q_o[n*NIB_W +: NIB_W] <= wr_data_i[SLOT*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nibble_gpio_port.sv
module nibble_gpio_port
  import gpio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        strap_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic [15:0]       pad_in_i,
  output logic [15:0]       pad_out_o,
  output logic [15:0]       pad_oe_o
);
  reg_addr_e            addr;
  logic                 dir_we;
  logic [NUM_BYTES-1:0] byte_we;
  logic [NUM_NIB-1:0]   dir_q;
  logic [LINES-1:0]     pin_sync;

  assign addr    = reg_addr_e'(reg_addr_i);
  assign dir_we  = wr_en_i && (addr == ADDR_DIR);
  assign byte_we = {wr_en_i && (addr == ADDR_HI), wr_en_i && (addr == ADDR_LO)};

  gpio_dir_reg u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dir_we),
    .d_i    (wr_data_i[NUM_NIB-1:0]),
    .dir_o  (dir_q)
  );

  gpio_out_latch u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .byte_we_i (byte_we),
    .wr_data_i (wr_data_i),
    .q_o       (pad_out_o)
  );

  gpio_in_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_oe
    assign pad_oe_o[n*NIB_W +: NIB_W] = {NIB_W{~dir_q[n]}};
  end

  always_comb begin
    unique case (addr)
      ADDR_DIR: rd_data_o = {{(BYTE_W-NUM_NIB){1'b0}}, dir_q};
      ADDR_LO:  rd_data_o = pin_sync[0 +: BYTE_W];
      ADDR_HI:  rd_data_o = pin_sync[BYTE_W +: BYTE_W];
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  reg_addr_i,
  input logic        wr_en_i,
  input logic [7:0]  wr_data_i,
  input logic [7:0]  rd_data_o,
  input logic [15:0] pad_in_i,
  input logic [15:0] pad_out_o,
  input logic [15:0] pad_oe_o
);
  logic [1:0] live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  function automatic logic [15:0] oe_of(input logic [3:0] d);
    logic [15:0] r;
    for (int n = 0; n < 4; n++) r[n*4 +: 4] = {4{~d[n]}};
    return r;
  endfunction

  assert_dir_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_addr_i == 2'd0) |=> pad_oe_o == oe_of($past(wr_data_i[3:0])));

  assert_lo_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_addr_i == 2'd1) |=> pad_out_o[7:0] == $past(wr_data_i));

  assert_hi_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_addr_i == 2'd2) |=> pad_out_o[15:8] == $past(wr_data_i));

  assert_lo_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q >= 2'd2 && reg_addr_i == 2'd1) |-> rd_data_o == $past(pad_in_i[7:0], 2));

  assert_hi_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q >= 2'd2 && reg_addr_i == 2'd2) |-> rd_data_o == $past(pad_in_i[15:8], 2));

  assert_unused_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && reg_addr_i == 2'd3) |=> $stable(pad_out_o) && $stable(pad_oe_o));

  assert_unused_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd3) |-> rd_data_o == 8'h00);

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pad_out_o) && $stable(pad_oe_o));
endmodule

bind nibble_gpio_port gpio_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .pad_in_i   (pad_in_i),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/nibble_gpio_port_tb.sv
module nibble_gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [3:0]  strap = 4'b1010;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pins;
  logic [15:0] pout;
  logic [15:0] poe;
  logic [15:0] ext = 16'h0000;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0]  m_dir;
  logic [15:0] m_lat;

  always #10 clk = ~clk;

  // board model: driven lines show the latch, others the external source
  for (genvar i = 0; i < 16; i++) begin : g_pad
    assign pins[i] = poe[i] ? pout[i] : ext[i];
  end

  nibble_gpio_port u_dut (
    .clk_i (clk), .rst_ni (rst_n), .strap_i (strap),
    .reg_addr_i (addr), .wr_en_i (wr_en), .wr_data_i (wdata),
    .rd_data_o (rdata), .pad_in_i (pins), .pad_out_o (pout), .pad_oe_o (poe)
  );

  function automatic logic [15:0] exp_oe(input logic [3:0] d);
    logic [15:0] r;
    for (int n = 0; n < 4; n++) r[n*4 +: 4] = {4{~d[n]}};
    return r;
  endfunction

  function automatic logic [15:0] exp_strap(input logic [3:0] s);
    logic [15:0] r;
    for (int n = 0; n < 4; n++) r[n*4 +: 4] = {4{s[n]}};
    return r;
  endfunction

  function automatic logic [15:0] exp_pins(input logic [3:0] d, input logic [15:0] l,
                                           input logic [15:0] e);
    logic [15:0] oe;
    oe = exp_oe(d);
    return (oe & l) | (~oe & e);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    if (a == 2'd0) m_dir = d[3:0];
    if (a == 2'd1) m_lat[7:0] = d;
    if (a == 2'd2) m_lat[15:8] = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] lo, hi, dr;
    logic [15:0] ep;
    chk({tag, " R3 enables"}, poe, exp_oe(m_dir));
    chk({tag, " R4 latches"}, pout, m_lat);
    repeat (3) @(negedge clk);
    ep = exp_pins(m_dir, m_lat, ext);
    rd(2'd1, lo); rd(2'd2, hi); rd(2'd0, dr);
    chk({tag, " R5 readback"}, {hi, lo}, ep);
    chk({tag, " R7 dir read"}, {8'h00, dr}, {12'h000, m_dir});
  endtask

  task automatic do_reset(input logic [3:0] s);
    logic [7:0] d;
    strap = s;
    @(negedge clk); #2 rst_n = 1'b0;
    m_dir = '0; m_lat = exp_strap(s);
    @(negedge clk);
    chk("R1 enables under reset", poe, 16'hFFFF);
    chk("R2 strap level under reset", pout, exp_strap(s));
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d);
    chk("R1 dir read after reset", {8'h00, d}, 16'h0000);
    chk("R1 enables after reset", poe, 16'hFFFF);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    m_dir = '0; m_lat = '0;
    do_reset(4'b1010);
    chk("R2 strap 1010", pout, 16'hF0F0);
    do_reset(4'b0101);
    chk("R2 strap 0101", pout, 16'h0F0F);

    // R4 directed byte writes
    wr(2'd1, 8'hA5); check_all("lo");
    wr(2'd2, 8'h3C); check_all("hi");
    chk("R4 full word", pout, 16'h3CA5);

    // R3 direction, external differs from latch
    ext = 16'h5A5A;
    wr(2'd0, 8'hF5); check_all("dir F5");
    chk("R3 nibbles 0,2 input", poe, 16'hF0F0);

    // R6 write into input nibble, then switch to output
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h96);
    chk("R6 latch under input", pout[7:0], 8'h96);
    check_all("R6 input");
    wr(2'd0, 8'h00);
    chk("R6 drives latched value", pout, {8'h3C, 8'h96});
    check_all("R6 output");

    // R7 unused address
    wr(2'd3, 8'hFF);
    chk("R7 addr3 write no effect out", pout, m_lat);
    chk("R7 addr3 write no effect oe", poe, exp_oe(m_dir));
    rd(2'd3, d);
    chk("R7 addr3 reads zero", {8'h00, d}, 16'h0000);

    // R8 strobe low
    @(negedge clk); addr = 2'd1; wdata = 8'h00;
    @(negedge clk); addr = 2'd0; wdata = 8'hFF;
    @(negedge clk); addr = 2'd2; wdata = 8'h11;
    @(negedge clk);
    chk("R8 no write out", pout, m_lat);
    chk("R8 no write oe", poe, exp_oe(m_dir));

    for (int it = 0; it < 300; it++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      ext = 16'($urandom);
      if ($urandom_range(0, 3) != 0) wr(a, 8'($urandom));
      check_all("rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule